// File: doc/BRIEF.md
# Watchdog Register Front End with Two-Step Unlock

This block sits between a simple register request strobe and a watchdog timer core. It decodes a 16-byte little-endian window that accepts byte, 16-bit and 32-bit accesses. Any write that changes the timer is protected. Software must first write the key 0x80 and then the key 0x86 to offset 0xC. Only after that pair is one protected write accepted. The block then relocks itself.

Accepted protected writes reach the core as registered one-cycle strobes. There are two preload-load strobes, which share a 20-bit value bus, a reload (keep-alive) strobe and a strobe that clears the previous-reboot flag. The flag itself is owned by the core and comes back in as an input. The block reports it on 16-bit reads of offset 0xC. A read request returns its data one cycle later.

Top module: `wdt_regfront`

## Requirements
- R1: A write of 0x80 to offset 0xC arms the unlock sequence. The write may be of any size, and the key is compared against the data masked to the access size. This applies in every unlock state, including when the block is already fully unlocked.
- R2: A write of 0x86 to offset 0xC while the block is armed fully unlocks it. A 0x86 write in any other state does not unlock it.
- R3: While the block is fully unlocked, the next 16-bit or 32-bit write that is not the key 0x80 is the single protected write. It relocks the block, whatever its address or effect, so a later write has no effect until the block is unlocked again.
- R4: A protected 32-bit write to offset 0x0 pulses `preload1_we` for one cycle. A protected 32-bit write to offset 0x4 pulses `preload2_we` for one cycle. In both cases `preload_val` carries data bits 19:0. A 16-bit write to these offsets loads nothing.
- R5: A protected 16-bit write to offset 0xC with data bit 8 set pulses `reload_pulse` for one cycle.
- R6: A protected 16-bit write to offset 0xC with data bit 9 or data bit 12 set pulses `flag_clr_pulse` for one cycle.
- R7: A read is answered on the cycle after the request, with `rd_valid` high for one cycle. A 16-bit read of offset 0xC returns 0x1200 while `prev_reboot` is high and 0 while it is low. Every other read returns 0.
- R8: A byte write never performs a protected update and does not relock the block. It can only take the unlock steps of R1 and R2.
- R9: In the locked or armed state, a write that is not an unlock key is ignored and leaves the unlock state unchanged.
- R10: Synchronous reset relocks the block and clears all strobes and read outputs.
- R11: An action strobe is registered. It appears in the cycle after the request and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset inside the window |
| req_size | input | 3 | Access size code: 1, 2 or 4 bytes |
| req_wdata | input | 32 | Write data, least significant byte first |
| prev_reboot | input | 1 | Previous-reboot flag from the timer core |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| preload1_we | output | 1 | Load strobe for the stage-1 preload |
| preload2_we | output | 1 | Load strobe for the stage-2 preload |
| preload_val | output | 20 | Preload value for the strobed stage |
| reload_pulse | output | 1 | Keep-alive strobe to the timer core |
| flag_clr_pulse | output | 1 | Clear strobe for the previous-reboot flag |

## Verification
The unlock sequence is tried with several key orders: keys of each access size, the second key without the first, a non-key write between the two keys, and a first key repeated after a full unlock. Together these show which transitions the state machine takes and which writes it ignores. Protected writes are varied by size, offset and data bit. This separates the two preload targets, the reload bit, the two flag-clear bits and the writes that use up an unlock without doing anything. Byte writes made while the block is unlocked show that bytes never use up the unlock. Reads are taken at several sizes and offsets with the flag both set and clear.

// File: rtl/wdtfe_pkg.sv
package wdtfe_pkg;
  typedef enum logic [1:0] {
    UL_LOCKED = 2'd0,
    UL_ARMED  = 2'd1,
    UL_OPEN   = 2'd2
  } unlock_t;

  localparam logic [2:0] SZ_BYTE = 3'd1;
  localparam logic [2:0] SZ_WORD = 3'd2;
  localparam logic [2:0] SZ_LONG = 3'd4;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;
endpackage

// File: rtl/wdtfe_decode.sv
module wdtfe_decode
  import wdtfe_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] OFF_PRE1 = 'h0,
  parameter logic [ADDR_W-1:0] OFF_PRE2 = 'h4,
  parameter logic [ADDR_W-1:0] OFF_CTL  = 'hC
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              wr_any,
  output logic              wr_wide,
  output logic              wr_long,
  output logic              wr_word,
  output logic              key_first,
  output logic              key_second,
  output logic              hit_pre1,
  output logic              hit_pre2,
  output logic              hit_ctl,
  output logic              rd_any,
  output logic              rd_ctl_word,
  output logic [DATA_W-1:0] wdata_masked
);
  logic size_ok;

  always_comb begin
    size_ok = (req_size == SZ_BYTE) || (req_size == SZ_WORD) || (req_size == SZ_LONG);
    wdata_masked = '0;
    case (req_size)
      SZ_BYTE: wdata_masked[7:0]  = req_wdata[7:0];
      SZ_WORD: wdata_masked[15:0] = req_wdata[15:0];
      default: wdata_masked       = req_wdata;
    endcase
    wr_any      = req_valid && req_write && size_ok;
    rd_any      = req_valid && !req_write && size_ok;
    wr_long     = wr_any && (req_size == SZ_LONG);
    wr_word     = wr_any && (req_size == SZ_WORD);
    wr_wide     = wr_long || wr_word;
    hit_pre1    = (req_addr == OFF_PRE1);
    hit_pre2    = (req_addr == OFF_PRE2);
    hit_ctl     = (req_addr == OFF_CTL);
    key_first   = hit_ctl && (wdata_masked == DATA_W'(KEY_FIRST));
    key_second  = hit_ctl && (wdata_masked == DATA_W'(KEY_SECOND));
    rd_ctl_word = rd_any && hit_ctl && (req_size == SZ_WORD);
  end
endmodule

// File: rtl/wdtfe_unlock.sv
module wdtfe_unlock
  import wdtfe_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_any,
  input  logic    wr_wide,
  input  logic    key_first,
  input  logic    key_second,
  output unlock_t state,
  output logic    grant
);
  unlock_t state_nx;

  always_comb begin
    grant    = wr_wide && (state == UL_OPEN) && !key_first;
    state_nx = state;
    if (wr_any && key_first)
      state_nx = UL_ARMED;
    else if (wr_any && key_second && (state == UL_ARMED))
      state_nx = UL_OPEN;
    else if (grant)
      state_nx = UL_LOCKED;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= UL_LOCKED;
    else     state <= state_nx;
  end

  p_key_first_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_any && key_first) |=> (state == UL_ARMED));

  p_key_second_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_any && key_second && state == UL_ARMED) |=> (state == UL_OPEN));

  p_single_shot_r3: assert property (@(posedge clk) disable iff (rst)
    grant |=> (state == UL_LOCKED));

  p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_any && !key_first && (state == UL_LOCKED || (state == UL_ARMED && !key_second)))
    |=> $stable(state));

  p_legal_state_r10: assert property (@(posedge clk) disable iff (rst)
    state != 2'd3);
endmodule

// File: rtl/wdtfe_rdata.sv
module wdtfe_rdata #(
  parameter int DATA_W   = 32,
  parameter int FLAG_BIT_A = 9,
  parameter int FLAG_BIT_B = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_any,
  input  logic              rd_ctl_word,
  input  logic              flag,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] FLAG_WORD =
    (DATA_W'(1) << FLAG_BIT_A) | (DATA_W'(1) << FLAG_BIT_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_any;
      if (rd_any)
        rd_data <= (rd_ctl_word && flag) ? FLAG_WORD : '0;
    end
  end

  p_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_any && !rd_ctl_word) |=> (rd_data == '0));

  p_read_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_ctl_word && flag) |=> (rd_data != '0) && rd_valid);
endmodule

// File: rtl/wdt_regfront.sv
module wdt_regfront
  import wdtfe_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int PRELOAD_W  = 20,
  parameter int RELOAD_BIT = 8,
  parameter int CLR_BIT_A  = 9,
  parameter int CLR_BIT_B  = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [2:0]           req_size,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 prev_reboot,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 preload1_we,
  output logic                 preload2_we,
  output logic [PRELOAD_W-1:0] preload_val,
  output logic                 reload_pulse,
  output logic                 flag_clr_pulse
);
  logic wr_any, wr_wide, wr_long, wr_word, key_first, key_second;
  logic hit_pre1, hit_pre2, hit_ctl, rd_any, rd_ctl_word, grant;
  logic [DATA_W-1:0] wdata_masked;
  unlock_t state;

  wdtfe_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .wr_any(wr_any), .wr_wide(wr_wide), .wr_long(wr_long), .wr_word(wr_word),
    .key_first(key_first), .key_second(key_second),
    .hit_pre1(hit_pre1), .hit_pre2(hit_pre2), .hit_ctl(hit_ctl),
    .rd_any(rd_any), .rd_ctl_word(rd_ctl_word), .wdata_masked(wdata_masked)
  );

  wdtfe_unlock u_unlock (
    .clk(clk), .rst(rst), .wr_any(wr_any), .wr_wide(wr_wide),
    .key_first(key_first), .key_second(key_second),
    .state(state), .grant(grant)
  );

  wdtfe_rdata #(.DATA_W(DATA_W), .FLAG_BIT_A(CLR_BIT_A), .FLAG_BIT_B(CLR_BIT_B)) u_rdata (
    .clk(clk), .rst(rst), .rd_any(rd_any), .rd_ctl_word(rd_ctl_word),
    .flag(prev_reboot), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  logic act_pre1, act_pre2, act_reload, act_clr;

  always_comb begin
    act_pre1   = grant && wr_long && hit_pre1;
    act_pre2   = grant && wr_long && hit_pre2;
    act_reload = grant && wr_word && hit_ctl && wdata_masked[RELOAD_BIT];
    act_clr    = grant && wr_word && hit_ctl &&
                 (wdata_masked[CLR_BIT_A] || wdata_masked[CLR_BIT_B]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preload1_we    <= 1'b0;
      preload2_we    <= 1'b0;
      preload_val    <= '0;
      reload_pulse   <= 1'b0;
      flag_clr_pulse <= 1'b0;
    end else begin
      preload1_we    <= act_pre1;
      preload2_we    <= act_pre2;
      reload_pulse   <= act_reload;
      flag_clr_pulse <= act_clr;
      if (act_pre1 || act_pre2)
        preload_val <= wdata_masked[PRELOAD_W-1:0];
    end
  end

  p_byte_inert_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_size == SZ_BYTE)
    |=> !(preload1_we || preload2_we || reload_pulse || flag_clr_pulse));

  p_one_target_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({preload1_we, preload2_we, reload_pulse || flag_clr_pulse}));

  p_locked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (state != UL_OPEN) |=> !(preload1_we || preload2_we || reload_pulse || flag_clr_pulse));

  p_pulse_short_r11: assert property (@(posedge clk) disable iff (rst)
    reload_pulse |=> !reload_pulse);
endmodule

// File: tb/tb_wdt_regfront.sv
module tb_wdt_regfront;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 38;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [3:0]  req_addr;
  logic [2:0]  req_size;
  logic [31:0] req_wdata;
  logic        prev_reboot;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        preload1_we, preload2_we, reload_pulse, flag_clr_pulse;
  logic [19:0] preload_val;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_regfront dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .prev_reboot(prev_reboot), .rd_valid(rd_valid), .rd_data(rd_data),
    .preload1_we(preload1_we), .preload2_we(preload2_we), .preload_val(preload_val),
    .reload_pulse(reload_pulse), .flag_clr_pulse(flag_clr_pulse)
  );

  // Row layout: [99:96] requirement number, [95] write, [94:92] size,
  // [91:88] offset, [87:56] data, [55] pre1, [54] pre2, [53] reload,
  // [52] clear, [51:32] preload value, [31:0] read data.
  localparam logic [99:0] VEC [NV] = '{
    {4'd7, 1'b0,3'd2,4'hC,32'h0,        4'b0000,20'h0,    32'h1200}, // R7 flag read
    {4'd7, 1'b0,3'd4,4'hC,32'h0,        4'b0000,20'h0,    32'h0},    // R7 long read
    {4'd7, 1'b0,3'd1,4'hC,32'h0,        4'b0000,20'h0,    32'h0},    // R7 byte read
    {4'd9, 1'b1,3'd4,4'h0,32'h123,      4'b0000,20'h0,    32'h0},    // R9 locked
    {4'd2, 1'b1,3'd2,4'hC,32'h86,       4'b0000,20'h0,    32'h0},    // R2 without first key
    {4'd9, 1'b1,3'd4,4'h0,32'h456,      4'b0000,20'h0,    32'h0},    // R9 still locked
    {4'd1, 1'b1,3'd1,4'hC,32'hFFFF_FF80,4'b0000,20'h0,    32'h0},    // R1 byte key, upper bits masked
    {4'd2, 1'b1,3'd1,4'hC,32'h86,       4'b0000,20'h0,    32'h0},    // R2 byte key
    {4'd8, 1'b1,3'd1,4'hC,32'h1,        4'b0000,20'h0,    32'h0},    // R8 byte no effect
    {4'd4, 1'b1,3'd4,4'h0,32'hABC1_2345,4'b1000,20'h12345,32'h0},    // R4 preload 1
    {4'd3, 1'b1,3'd4,4'h4,32'h5_5555,   4'b0000,20'h0,    32'h0},    // R3 relocked
    {4'd1, 1'b1,3'd2,4'hC,32'h80,       4'b0000,20'h0,    32'h0},
    {4'd2, 1'b1,3'd2,4'hC,32'h86,       4'b0000,20'h0,    32'h0},
    {4'd4, 1'b1,3'd4,4'h4,32'hFFFF_FFFF,4'b0100,20'hFFFFF,32'h0},    // R4 preload 2
    {4'd1, 1'b1,3'd2,4'hC,32'h80,       4'b0000,20'h0,    32'h0},
    {4'd9, 1'b1,3'd2,4'hC,32'h100,      4'b0000,20'h0,    32'h0},    // R9 armed, ignored
    {4'd2, 1'b1,3'd2,4'hC,32'h86,       4'b0000,20'h0,    32'h0},    // R2 still armed
    {4'd5, 1'b1,3'd2,4'hC,32'h100,      4'b0010,20'h0,    32'h0},    // R5 reload
    {4'd1, 1'b1,3'd4,4'hC,32'h80,       4'b0000,20'h0,    32'h0},
    {4'd2, 1'b1,3'd4,4'hC,32'h86,       4'b0000,20'h0,    32'h0},
    {4'd6, 1'b1,3'd2,4'hC,32'h1000,     4'b0001,20'h0,    32'h0},    // R6 bit 12
    {4'd1, 1'b1,3'd2,4'hC,32'h80,       4'b0000,20'h0,    32'h0},
    {4'd2, 1'b1,3'd2,4'hC,32'h86,       4'b0000,20'h0,    32'h0},
    {4'd6, 1'b1,3'd2,4'hC,32'h200,      4'b0001,20'h0,    32'h0},    // R6 bit 9
    {4'd1, 1'b1,3'd2,4'hC,32'h80,       4'b0000,20'h0,    32'h0},
    {4'd2, 1'b1,3'd2,4'hC,32'h86,       4'b0000,20'h0,    32'h0},
    {4'd1, 1'b1,3'd2,4'hC,32'h80,       4'b0000,20'h0,    32'h0},    // R1 rearm from open
    {4'd9, 1'b1,3'd2,4'hC,32'h100,      4'b0000,20'h0,    32'h0},    // R9 back to armed
    {4'd2, 1'b1,3'd2,4'hC,32'h86,       4'b0000,20'h0,    32'h0},
    {4'd5, 1'b1,3'd2,4'hC,32'h1100,     4'b0011,20'h0,    32'h0},    // R5 reload and clear
    {4'd1, 1'b1,3'd2,4'hC,32'h80,       4'b0000,20'h0,    32'h0},
    {4'd2, 1'b1,3'd2,4'hC,32'h86,       4'b0000,20'h0,    32'h0},
    {4'd3, 1'b1,3'd2,4'h8,32'h100,      4'b0000,20'h0,    32'h0},    // R3 used by wrong offset
    {4'd3, 1'b1,3'd2,4'hC,32'h100,      4'b0000,20'h0,    32'h0},    // R3 relocked
    {4'd1, 1'b1,3'd2,4'hC,32'h80,       4'b0000,20'h0,    32'h0},
    {4'd2, 1'b1,3'd2,4'hC,32'h86,       4'b0000,20'h0,    32'h0},
    {4'd4, 1'b1,3'd2,4'h0,32'h1234,     4'b0000,20'h0,    32'h0},    // R4 16-bit preload loads nothing
    {4'd3, 1'b1,3'd4,4'h0,32'h1,        4'b0000,20'h0,    32'h0}     // R3 relocked
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input int req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [2:0] sz,
                       input logic [3:0] ad, input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = ad; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic chk_quiet(input int req, input string what);
    chk({28'h0, preload1_we, preload2_we, reload_pulse, flag_clr_pulse}, 32'h0, req, what);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    n_checks++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = 3'd2; req_wdata = '0; prev_reboot = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state of outputs
    chk_quiet(10, "strobes in reset");
    chk({31'h0, rd_valid}, 32'h0, 10, "rd_valid in reset");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [99:0] v;
      v = VEC[i];
      drive(v[95], v[94:92], v[91:88], v[87:56]);
      chk({28'h0, preload1_we, preload2_we, reload_pulse, flag_clr_pulse},
          {28'h0, v[55:52]}, int'(v[99:96]), $sformatf("strobes row %0d", i));
      if (v[55] || v[54])
        chk({12'h0, preload_val}, {12'h0, v[51:32]}, 4, $sformatf("preload row %0d", i));
      if (!v[95]) begin
        chk({31'h0, rd_valid}, 32'h1, 7, $sformatf("rd_valid row %0d", i));
        chk(rd_data, v[31:0], 7, $sformatf("rd_data row %0d", i));
      end
      // R11 strobes last one cycle
      @(negedge clk);
      chk_quiet(11, $sformatf("strobe width row %0d", i));
    end

    // R7 flag low
    prev_reboot = 1'b0;
    drive(1'b0, 3'd2, 4'hC, 32'h0);
    chk(rd_data, 32'h0, 7, "flag clear read");
    chk({31'h0, rd_valid}, 32'h1, 7, "rd_valid flag clear");
    @(negedge clk);
    chk({31'h0, rd_valid}, 32'h0, 7, "rd_valid one cycle");

    // R10 reset relocks an open block
    drive(1'b1, 3'd2, 4'hC, 32'h80);
    drive(1'b1, 3'd2, 4'hC, 32'h86);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 3'd4, 4'h0, 32'h77);
    chk_quiet(10, "write after reset relocks");

    // R8 byte write while open does not relock; next word write still protected
    drive(1'b1, 3'd2, 4'hC, 32'h80);
    drive(1'b1, 3'd2, 4'hC, 32'h86);
    drive(1'b1, 3'd1, 4'h0, 32'h1);
    chk_quiet(8, "byte write in open state");
    drive(1'b1, 3'd4, 4'h0, 32'h3_3333);
    chk({31'h0, preload1_we}, 32'h1, 8, "unlock kept across byte write");
    chk({12'h0, preload_val}, 32'h3_3333, 4, "preload after byte write");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule